// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block turns the four legacy PCI interrupt pins into system interrupt line numbers. It keeps a four-entry table of 8-bit IRQ numbers, one entry per pin, each indexed by pin number minus one (INTA# is index 0 and INTD# is index 3). An entry is either a number written by software or the reserved value 0xFF, which marks it as unconfigured. An unconfigured entry takes a default from a 2-bit routing mode and a base IRQ number. In modes 0 and 1 all pins share the base line. In modes 2 and 3 each pin gets its own line, counted up from the base.

A registered lookup port answers the question "which system IRQ serves pin P of the device in slot S?". For devices on bus 0 it applies the slot-based pin rotation. The block also fans raw pin, DMA and error interrupt inputs out onto a vector of system interrupt lines. It presents a control word with a per-pin enable mask and the error enable.

Top module: `pci_irq_router`

## Requirements
- R1: After reset every table entry is unconfigured (0xFF), `lu_valid_o` is 0 and `sys_irq_o` is all zeros.
- R2: An unconfigured entry resolves to `base_irq_i` when `mode_i` is 0 or 1.
- R3: An unconfigured entry for pin index k (0..3) resolves to `base_irq_i + k`, modulo 256, when `mode_i` is 2 or 3.
- R4: A write (`wr_en_i`, `wr_idx_i`, `wr_data_i`) stores an entry that overrides the default in every mode and is kept until reset. Writing 0xFF returns the entry to its mode-derived default.
- R5: An entry that resolves to 0 is disabled. `ctrl_o[3:0]` holds the enable mask, with bit k set exactly when the entry for pin index k resolves to a nonzero value.
- R6: A lookup with `lu_bus0_i`=1 and pin P in 1..4 returns the entry at index ((P-1) + (slot mod 4)) mod 4.
- R7: A lookup with `lu_bus0_i`=0 and pin P in 1..4 returns the entry at index P-1, whatever the slot.
- R8: A lookup with pin 0 or pin 5..7 returns 0.
- R9: A lookup result appears on `lu_irq_o` with `lu_valid_o`=1 one cycle after `lu_valid_i`. `lu_valid_o` is 0 in the cycle after an idle request.
- R10: `dma_line_o` is `base_irq_i` plus an offset chosen by the mode: 1 in mode 1, 4 in mode 3, and 0 in modes 0 and 2.
- R11: One cycle after the inputs, bit n of `sys_irq_o` is set exactly when one of these holds: an asserted pin whose mask bit is set resolves to n; `dma_irq_i` is high and `dma_line_o` is n; or `err_irq_i` and `err_en_i` are both high and `base_irq_i` is n. Numbers at or above NUM_SYS drive no line.
- R12: `ctrl_o[24]` reflects `err_en_i`, and all other control bits above 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Routing mode |
| base_irq_i | input | 8 | Base system IRQ number |
| err_en_i | input | 1 | Error interrupt enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 2 | Table entry index (pin-1) |
| wr_data_i | input | 8 | Table write value |
| lu_valid_i | input | 1 | Lookup request |
| lu_bus0_i | input | 1 | Device sits on bus 0 |
| lu_slot_i | input | SLOT_W | Device slot number |
| lu_pin_i | input | PIN_W | Interrupt pin, 1..4 valid |
| lu_valid_o | output | 1 | Lookup result valid |
| lu_irq_o | output | 8 | Looked-up IRQ number, 0 if none |
| pin_raw_i | input | 4 | Raw pin interrupts, bit k = pin index k |
| dma_irq_i | input | 1 | DMA interrupt request |
| err_irq_i | input | 1 | Error interrupt request |
| dma_line_o | output | 8 | System IRQ number used for DMA |
| ctrl_o | output | 32 | Control word: enable mask [3:0], error enable [24] |
| sys_irq_o | output | NUM_SYS | System interrupt lines |

## Verification
A corrupted table entry would show up on the very next lookup that selects it, so sweeping every slot residue and pin under each mode exposes it within two cycles. The same fault appears in the enable mask on `ctrl_o` in the same cycle. A wrong rotation or default shows up as a mismatched number for particular slot and pin pairs, with the base value chosen so that the per-pin sum wraps past 255. A fault in the fan-out shows up on `sys_irq_o` one cycle after the raw pins change. The bench covers this with a full sweep of raw-pin, DMA and error combinations, including one entry that maps outside the line range.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  localparam int unsigned NUM_PINS = 4;
  localparam int unsigned IRQ_W    = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_PINS);
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned ERR_BIT  = 24;
  localparam logic [IRQ_W-1:0] UNSET = '1;

  typedef logic [IRQ_W-1:0] irq_num_t;

  typedef enum logic [1:0] {
    MODE_SHARED    = 2'd0,
    MODE_SHARED_D1 = 2'd1,
    MODE_PERPIN    = 2'd2,
    MODE_PERPIN_D4 = 2'd3
  } route_mode_e;

  function automatic irq_num_t dma_offset(route_mode_e m);
    case (m)
      MODE_SHARED_D1: return irq_num_t'(1);
      MODE_PERPIN_D4: return irq_num_t'(4);
      default:        return '0;
    endcase
  endfunction
endpackage

// File: rtl/pci_irq_table.sv
module pci_irq_table
  import pci_irq_router_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  irq_num_t                             wr_data_i,
  input  route_mode_e                          mode_i,
  input  irq_num_t                             base_i,
  output logic [NUM_PINS-1:0][IRQ_W-1:0]       eff_o,
  output logic [NUM_PINS-1:0]                  mask_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    irq_num_t entry_q;
    irq_num_t dflt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  entry_q <= UNSET;
      else if (wr_en_i && wr_idx_i == IDX_W'(p))    entry_q <= wr_data_i;
    end

    // per-pin modes spread the pins over consecutive lines
    always_comb begin
      dflt = mode_i[1] ? irq_num_t'(base_i + irq_num_t'(p)) : base_i;
      eff_o[p]  = (entry_q == UNSET) ? dflt : entry_q;
      mask_o[p] = |eff_o[p];
    end
  end
endmodule

// File: rtl/pci_irq_rotator.sv
module pci_irq_rotator
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned PIN_W  = 3
) (
  input  logic                           bus0_i,
  input  logic [SLOT_W-1:0]              slot_i,
  input  logic [PIN_W-1:0]               pin_i,
  input  logic [NUM_PINS-1:0][IRQ_W-1:0] eff_i,
  output irq_num_t                       irq_o
);
  logic             pin_ok;
  logic [IDX_W-1:0] pin_m1;
  logic [IDX_W-1:0] idx;

  always_comb begin
    pin_ok = (pin_i >= PIN_W'(1)) && (pin_i <= PIN_W'(NUM_PINS));
    pin_m1 = IDX_W'(pin_i - PIN_W'(1));
    idx    = bus0_i ? IDX_W'(slot_i + SLOT_W'(pin_m1)) : pin_m1;
    irq_o  = pin_ok ? eff_i[idx] : '0;
  end
endmodule

// File: rtl/pci_irq_fanout.sv
module pci_irq_fanout
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SYS = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PINS-1:0]            pin_raw_i,
  input  logic [NUM_PINS-1:0][IRQ_W-1:0] eff_i,
  input  logic [NUM_PINS-1:0]            mask_i,
  input  logic                           dma_irq_i,
  input  irq_num_t                       dma_line_i,
  input  logic                           err_irq_i,
  input  logic                           err_en_i,
  input  irq_num_t                       base_i,
  output logic [NUM_SYS-1:0]             sys_irq_o
);
  logic [NUM_SYS-1:0] hit_d;

  for (genvar n = 0; n < NUM_SYS; n++) begin : g_line
    always_comb begin
      hit_d[n] = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
        if (pin_raw_i[p] && mask_i[p] && eff_i[p] == irq_num_t'(n)) hit_d[n] = 1'b1;
      if (dma_irq_i && dma_line_i == irq_num_t'(n))            hit_d[n] = 1'b1;
      if (err_irq_i && err_en_i && base_i == irq_num_t'(n))    hit_d[n] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_irq_o <= '0;
    else         sys_irq_o <= hit_d;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SYS = 32,
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned PIN_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic [7:0]          base_irq_i,
  input  logic                err_en_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_idx_i,
  input  logic [7:0]          wr_data_i,
  input  logic                lu_valid_i,
  input  logic                lu_bus0_i,
  input  logic [SLOT_W-1:0]   lu_slot_i,
  input  logic [PIN_W-1:0]    lu_pin_i,
  output logic                lu_valid_o,
  output logic [7:0]          lu_irq_o,
  input  logic [3:0]          pin_raw_i,
  input  logic                dma_irq_i,
  input  logic                err_irq_i,
  output logic [7:0]          dma_line_o,
  output logic [31:0]         ctrl_o,
  output logic [NUM_SYS-1:0]  sys_irq_o
);
  route_mode_e                    mode;
  logic [NUM_PINS-1:0][IRQ_W-1:0] eff;
  logic [NUM_PINS-1:0]            mask;
  irq_num_t                       lu_irq_d;

  assign mode = route_mode_e'(mode_i);

  pci_irq_table u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .mode_i    (mode),
    .base_i    (base_irq_i),
    .eff_o     (eff),
    .mask_o    (mask)
  );

  pci_irq_rotator #(.SLOT_W(SLOT_W), .PIN_W(PIN_W)) u_rot (
    .bus0_i (lu_bus0_i),
    .slot_i (lu_slot_i),
    .pin_i  (lu_pin_i),
    .eff_i  (eff),
    .irq_o  (lu_irq_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lu_valid_o <= 1'b0;
      lu_irq_o   <= '0;
    end else begin
      lu_valid_o <= lu_valid_i;
      if (lu_valid_i) lu_irq_o <= lu_irq_d;
    end
  end

  assign dma_line_o = irq_num_t'(base_irq_i + dma_offset(mode));

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[NUM_PINS-1:0]     = mask;
    ctrl_o[ERR_BIT]          = err_en_i;
  end

  pci_irq_fanout #(.NUM_SYS(NUM_SYS)) u_fan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_raw_i  (pin_raw_i),
    .eff_i      (eff),
    .mask_i     (mask),
    .dma_irq_i  (dma_irq_i),
    .dma_line_i (dma_line_o),
    .err_irq_i  (err_irq_i),
    .err_en_i   (err_en_i),
    .base_i     (base_irq_i),
    .sys_irq_o  (sys_irq_o)
  );
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int unsigned NUM_SYS = 32,
  parameter int unsigned PIN_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic [7:0]         base_irq_i,
  input logic               lu_valid_i,
  input logic [PIN_W-1:0]   lu_pin_i,
  input logic               lu_valid_o,
  input logic [7:0]         lu_irq_o,
  input logic [3:0]         pin_raw_i,
  input logic               dma_irq_i,
  input logic               err_irq_i,
  input logic [7:0]         dma_line_o,
  input logic [NUM_SYS-1:0] sys_irq_o
);
  AST_LU_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_valid_i |=> lu_valid_o);  // R9
  AST_LU_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lu_valid_i |=> !lu_valid_o);  // R9
  AST_BAD_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_valid_i && (lu_pin_i == '0 || lu_pin_i > PIN_W'(4)) |=> lu_irq_o == 8'h00);  // R8
  AST_DMA_NO_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd2) |-> dma_line_o == base_irq_i);  // R10
  AST_QUIET_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_irq_i && !dma_irq_i && pin_raw_i == 4'h0) |=> sys_irq_o == '0);  // R11
endmodule

bind pci_irq_router pci_irq_router_chk #(.NUM_SYS(NUM_SYS), .PIN_W(PIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .base_irq_i (base_irq_i),
  .lu_valid_i (lu_valid_i),
  .lu_pin_i   (lu_pin_i),
  .lu_valid_o (lu_valid_o),
  .lu_irq_o   (lu_irq_o),
  .pin_raw_i  (pin_raw_i),
  .dma_irq_i  (dma_irq_i),
  .err_irq_i  (err_irq_i),
  .dma_line_o (dma_line_o),
  .sys_irq_o  (sys_irq_o)
);

// File: tb/pci_irq_router_bench.sv
`timescale 1ns/1ps
module pci_irq_router_bench;
  localparam int NUM_SYS = 32;
  localparam int SLOT_W  = 5;
  localparam int PIN_W   = 3;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [1:0]         mode_i = 2'd0;
  logic [7:0]         base_irq_i = 8'h10;
  logic               err_en_i = 1'b0;
  logic               wr_en_i = 1'b0;
  logic [1:0]         wr_idx_i = '0;
  logic [7:0]         wr_data_i = '0;
  logic               lu_valid_i = 1'b0;
  logic               lu_bus0_i = 1'b0;
  logic [SLOT_W-1:0]  lu_slot_i = '0;
  logic [PIN_W-1:0]   lu_pin_i = '0;
  logic               lu_valid_o;
  logic [7:0]         lu_irq_o;
  logic [3:0]         pin_raw_i = '0;
  logic               dma_irq_i = 1'b0;
  logic               err_irq_i = 1'b0;
  logic [7:0]         dma_line_o;
  logic [31:0]        ctrl_o;
  logic [NUM_SYS-1:0] sys_irq_o;

  int total = 0;
  int bad = 0;
  logic [7:0] m_tab [4];

  always #10 clk_i = ~clk_i;

  pci_irq_router #(.NUM_SYS(NUM_SYS), .SLOT_W(SLOT_W), .PIN_W(PIN_W)) u_pci_irq_router (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] m_eff(int k);
    if (m_tab[k] != 8'hFF) return m_tab[k];
    return mode_i[1] ? 8'(base_irq_i + 8'(k)) : base_irq_i;
  endfunction

  function automatic logic [3:0] m_mask();
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = (m_eff(k) != 8'h00);
    return m;
  endfunction

  task automatic wr(input int k, input logic [7:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 2'(k); wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_tab[k] = v;
  endtask

  // full lookup sweep for the current mode and base; R2 R3 R6 R7 R8 R9
  task automatic sweep();
    for (int b0 = 0; b0 < 2; b0++)
      for (int s = 0; s < 32; s++)
        for (int p = 0; p < 8; p++) begin
          logic [7:0] exp;
          if (p >= 1 && p <= 4) exp = m_eff(b0 ? ((p - 1 + s) & 3) : (p - 1));
          else exp = 8'h00;
          @(negedge clk_i);
          lu_valid_i = 1'b1; lu_bus0_i = b0[0]; lu_slot_i = 5'(s); lu_pin_i = 3'(p);
          @(negedge clk_i);
          lu_valid_i = 1'b0;
          chk(b0 ? "R6 bus0 rotated lookup" : "R7 R2 R3 R8 lookup", {56'h0, lu_irq_o}, {56'h0, exp});
          chk("R9 lookup valid", {63'h0, lu_valid_o}, 64'h1);
        end
  endtask

  task automatic mode_checks();
    logic [7:0] ofs;
    ofs = (mode_i == 2'd1) ? 8'd1 : (mode_i == 2'd3) ? 8'd4 : 8'd0;
    @(negedge clk_i);
    chk("R10 dma line", {56'h0, dma_line_o}, {56'h0, 8'(base_irq_i + ofs)});
    chk("R5 enable mask", {60'h0, ctrl_o[3:0]}, {60'h0, m_mask()});
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] bases [3];
    bases[0] = 8'h10; bases[1] = 8'hFE; bases[2] = 8'h00;
    for (int k = 0; k < 4; k++) m_tab[k] = 8'hFF;

    #5;
    chk("R1 reset lu_valid", {63'h0, lu_valid_o}, 64'h0);
    chk("R1 reset sys_irq", {32'h0, sys_irq_o}, 64'h0);
    #40 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 default mask after reset", {60'h0, ctrl_o[3:0]}, 64'hF);

    // no-write sweep over modes and bases
    for (int md = 0; md < 4; md++)
      for (int bi = 0; bi < 3; bi++) begin
        @(negedge clk_i);
        mode_i = 2'(md); base_irq_i = bases[bi];
        mode_checks();
        sweep();
      end

    // idle request clears valid, R9
    @(negedge clk_i);
    chk("R9 idle valid", {63'h0, lu_valid_o}, 64'h0);

    // R12 control word
    err_en_i = 1'b1;
    @(negedge clk_i);
    chk("R12 ctrl err enable", {32'h0, ctrl_o & 32'hFFFF_FFF0}, 64'h0100_0000);
    err_en_i = 1'b0;
    @(negedge clk_i);
    chk("R12 ctrl err disable", {32'h0, ctrl_o & 32'hFFFF_FFF0}, 64'h0);

    // software overrides, R4 R5
    mode_i = 2'd0; base_irq_i = 8'h10;
    wr(0, 8'h05);
    wr(1, 8'h00);
    wr(2, 8'h07);
    wr(2, 8'hFF);
    wr(3, 8'h21);
    for (int md = 0; md < 4; md++) begin
      @(negedge clk_i);
      mode_i = 2'(md);
      mode_checks();
      sweep();
    end

    // fan-out, R11
    @(negedge clk_i);
    mode_i = 2'd2; base_irq_i = 8'h10;
    for (int v = 0; v < 128; v++) begin
      logic [NUM_SYS-1:0] exp;
      logic [7:0] dl;
      @(negedge clk_i);
      pin_raw_i = v[3:0]; dma_irq_i = v[4]; err_irq_i = v[5]; err_en_i = v[6];
      exp = '0;
      for (int k = 0; k < 4; k++)
        if (v[k] && m_eff(k) != 8'h00 && m_eff(k) < NUM_SYS) exp[m_eff(k)] = 1'b1;
      dl = base_irq_i;
      if (v[4] && dl < NUM_SYS) exp[dl] = 1'b1;
      if (v[5] && v[6] && base_irq_i < NUM_SYS) exp[base_irq_i] = 1'b1;
      @(negedge clk_i);
      chk("R11 system lines", {32'h0, sys_irq_o}, {32'h0, exp});
    end
    // DMA with offset in mode 3, R10 R11
    @(negedge clk_i);
    pin_raw_i = '0; err_irq_i = 1'b0; err_en_i = 1'b0; mode_i = 2'd3; dma_irq_i = 1'b1;
    @(negedge clk_i);
    chk("R11 R10 dma line mode3", {32'h0, sys_irq_o}, {32'h0, 32'h0010_0000});
    dma_irq_i = 1'b0;
    @(negedge clk_i);
    chk("R11 quiet", {32'h0, sys_irq_o}, 64'h0);

    // reset clears written entries, R1 R4
    rst_ni = 1'b0;
    #5 rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) m_tab[k] = 8'hFF;
    mode_i = 2'd0;
    mode_checks();
    sweep();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule